// File: doc/BRIEF.md
# LED Matrix Scan Controller

This block refreshes a 192-column by 128-row single-colour LED matrix whose column and row drivers are chains of external serial-in, latched shift registers. Time is cut into fixed slots of 64 system clocks. During every slot the block reads 16 words of 16 bits from a frame buffer and stores them in a holding register. In the next slot it shifts that data out: word j goes onto column data line j, most significant bit first, and all 16 lines shift together under one shared shift clock.

Twelve slots fill one scan line of 192 columns on each of the 16 lines. The block then pulses the column latch, shifts one bit into the row-select chain and pulses the row latch. Rows are multiplexed 1-of-8. A marker bit is shifted in at row group 0 and walks one position per row group, so exactly one of the eight row positions is active. Eight row groups make one frame. After the eighth row latch a one-cycle frame pulse tells the buffer owner that it may swap banks. The scan position then returns to row group 0, slot 0.

The frame buffer is a synchronous-read memory with a read latency of one clock. The block drives only the read address. Bank selection is left to the user of the frame pulse.

Top module: `ledmx_scan_ctrl`

## Requirements
- R1: While reset is held, and in the clock after it, every control output and every column data line is 0 and `rd_addr` is 0. The first slot after reset only fetches: no column clock, latch, row clock or frame pulse occurs in it.
- R2: Let g be the slot count since reset (slot 0 is the first slot) and c be the cycle within the slot (0..63). Then `rd_addr` = r*192 + s*16 + c/4, where (r, s) = (row group, slot) of position g mod 96. The position is numbered so that row group r = p/12 and slot s = p mod 12. Each address is held for 4 clocks, and `rd_addr` always stays below 1536.
- R3: In slot g ≥ 1, let p = (g-1) mod 96 with r = p/12 and s = p mod 12. For c < 32, line j carries bit (15 - c/2) of the word at address r*192 + s*16 + j. That bit changes only at even c. For c ≥ 32 every line is 0.
- R4: In every slot g ≥ 1, `col_clk` is high exactly on the odd cycles c = 1, 3, ..., 31. This gives 16 rising edges, each one clock after its data change. The clock is low on all other cycles.
- R5: `col_latch` is high for one clock, at c = 40 of every slot whose shifted position has s = 11, and at no other time. At most one of the column clock, column latch, row clock, row latch and frame pulse is high in any cycle.
- R6: In a slot with s = 11, `row_clk` is high only at c = 46. `row_data` is 1 for c = 44..47 when r = 0 and is 0 at all other times. An external 8-bit shift register fed by these signals therefore holds a one-hot value with bit r set after row group r.
- R7: `row_latch` is high for one clock at c = 50 of every slot with s = 11, and at no other time.
- R8: `frame_pulse` is high for one clock at c = 51 of the slot with r = 7 and s = 11, and at no other time; the first one after reset occurs 6195 clocks after reset release. The next fetch and shift positions then wrap to r = 0, s = 0.
- R9: A synchronous reset asserted mid-frame restarts the whole schedule. Prefetch, address and shift timing and frame timing after release match those after a power-up reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr | output | 11 | Frame buffer word address (one screen) |
| rd_data | input | 16 | Frame buffer read data, one clock after the address |
| col_data | output | 16 | Serial column data, one line per column driver chain |
| col_clk | output | 1 | Shift clock shared by all column chains |
| col_latch | output | 1 | Column latch strobe, once per scan line |
| row_data | output | 1 | Serial input of the row-select chain |
| row_clk | output | 1 | Shift clock of the row-select chain |
| row_latch | output | 1 | Row-select latch strobe |
| frame_pulse | output | 1 | One-clock pulse after the last row group of a frame |

## Verification
A slot counter that is off by one shifts every address, every data edge and every strobe by one cycle. The cycle-exact comparison therefore shows it within the first slot after reset. A wrong fetch-ahead pointer or a wrong transpose leaves the strobes correct but puts the wrong pattern bit on some line at its first shifted bit, about 65 clocks after release. Errors in the row position appear only at slot 11: either as a non-one-hot value in the modelled external row register at the first row latch (clock 818), or as a frame pulse missing at clock 6195.

// File: rtl/ledmx_pkg.sv
// Package: shared types of the LED matrix scan controller.
// Assumes nothing beyond being compiled before the modules that import it.
package ledmx_pkg;

    // One-cycle strobes produced once per scan line by the timing unit.
    typedef struct packed {
        logic col_latch;
        logic row_data;
        logic row_clk;
        logic row_latch;
        logic frame;
    } ledmx_evt_t;

endpackage

// File: rtl/ledmx_timing.sv
// Module: slot timing unit.
// Counts clocks within a slot, keeps the position (row group, slot) of the
// data now being shifted, derives the position being fetched one slot ahead,
// and decodes the shift clock and the end-of-line strobes.
// Assumes the event cycles below fit inside one slot.
module ledmx_timing
    import ledmx_pkg::*;
#(
    parameter int SLOT_CLKS     = 64,
    parameter int SLOTS_PER_ROW = 12,
    parameter int ROW_GROUPS    = 8,
    parameter int WORD_W        = 16,
    parameter int BIT_CLKS      = 2,
    parameter int CYC_W         = 6,
    parameter int SLOT_W        = 4,
    parameter int ROW_W         = 3,
    parameter int BIT_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [CYC_W-1:0]  cyc,
    output logic [ROW_W-1:0]  row_f,
    output logic [SLOT_W-1:0] slot_f,
    output logic              slot_end,
    output logic              shift_active,
    output logic              col_clk,
    output logic [BIT_W-1:0]  bit_idx,
    output ledmx_evt_t        evt
);

    localparam int SHIFT_CLKS    = WORD_W * BIT_CLKS;
    localparam int COL_LATCH_CYC = SHIFT_CLKS + 8;
    localparam int ROW_DATA_CYC  = COL_LATCH_CYC + 4;
    localparam int ROW_DATA_LAST = ROW_DATA_CYC + 3;
    localparam int ROW_CLK_CYC   = ROW_DATA_CYC + 2;
    localparam int ROW_LATCH_CYC = ROW_CLK_CYC + 4;
    localparam int FRAME_CYC     = ROW_LATCH_CYC + 1;

    logic              shift_valid;
    logic [ROW_W-1:0]  row_s;
    logic [SLOT_W-1:0] slot_s;
    logic              line_end_slot;
    logic              last_row;

    assign slot_end      = (cyc == CYC_W'(SLOT_CLKS - 1));
    assign line_end_slot = shift_valid && (slot_s == SLOT_W'(SLOTS_PER_ROW - 1));
    assign last_row      = (row_s == ROW_W'(ROW_GROUPS - 1));

    // Slot clock counter plus the position of the data held for shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc         <= '0;
            shift_valid <= 1'b0;
            row_s       <= '0;
            slot_s      <= '0;
        end else begin
            cyc <= slot_end ? '0 : cyc + 1'b1;
            if (slot_end) begin
                shift_valid <= 1'b1;
                row_s       <= row_f;
                slot_s      <= slot_f;
            end
        end
    end

    // Fetch position: one slot ahead of shifting, (0,0) in the prefetch slot.
    always_comb begin
        row_f  = '0;
        slot_f = '0;
        if (shift_valid) begin
            if (slot_s == SLOT_W'(SLOTS_PER_ROW - 1)) begin
                slot_f = '0;
                row_f  = last_row ? '0 : row_s + 1'b1;
            end else begin
                slot_f = slot_s + 1'b1;
                row_f  = row_s;
            end
        end
    end

    // Shift window, bit index and mid-bit shift clock.
    always_comb begin
        shift_active = shift_valid && (cyc < CYC_W'(SHIFT_CLKS));
        bit_idx      = BIT_W'(cyc / CYC_W'(BIT_CLKS));
        col_clk      = shift_active &&
                       ((cyc % CYC_W'(BIT_CLKS)) >= CYC_W'(BIT_CLKS / 2));
    end

    // End-of-line strobes in the idle part of the last slot of a line.
    always_comb begin
        evt.col_latch = line_end_slot && (cyc == CYC_W'(COL_LATCH_CYC));
        evt.row_data  = line_end_slot && (row_s == '0) &&
                        (cyc >= CYC_W'(ROW_DATA_CYC)) &&
                        (cyc <= CYC_W'(ROW_DATA_LAST));
        evt.row_clk   = line_end_slot && (cyc == CYC_W'(ROW_CLK_CYC));
        evt.row_latch = line_end_slot && (cyc == CYC_W'(ROW_LATCH_CYC));
        evt.frame     = line_end_slot && last_row && (cyc == CYC_W'(FRAME_CYC));
    end

endmodule

// File: rtl/ledmx_fetch.sv
// Module: frame buffer fetch unit.
// Drives the read address for the fetch position and captures one word every
// FETCH_CLKS clocks into a per-line holding register.
// Assumes a synchronous-read buffer with one clock of latency and
// LINES * FETCH_CLKS <= slot length.
module ledmx_fetch #(
    parameter int LINES         = 16,
    parameter int WORD_W        = 16,
    parameter int SLOTS_PER_ROW = 12,
    parameter int FETCH_CLKS    = 4,
    parameter int CYC_W         = 6,
    parameter int ROW_W         = 3,
    parameter int SLOT_W        = 4,
    parameter int ADDR_W        = 11,
    parameter int LINE_W        = 4
) (
    input  logic                          clk,
    input  logic [CYC_W-1:0]              cyc,
    input  logic [ROW_W-1:0]              row_f,
    input  logic [SLOT_W-1:0]             slot_f,
    output logic [ADDR_W-1:0]             rd_addr,
    input  logic [WORD_W-1:0]             rd_data,
    output logic [LINES-1:0][WORD_W-1:0]  fetch_buf
);

    localparam int ROW_WORDS = SLOTS_PER_ROW * LINES;
    localparam int CAP_PH    = FETCH_CLKS / 2;

    logic [CYC_W-1:0]  word_full;
    logic [LINE_W-1:0] word_idx;
    logic              fetch_en;
    logic              capture;

    // Word index within the slot and capture timing.
    always_comb begin
        word_full = cyc / CYC_W'(FETCH_CLKS);
        word_idx  = LINE_W'(word_full);
        fetch_en  = (word_full < CYC_W'(LINES));
        capture   = fetch_en && ((cyc % CYC_W'(FETCH_CLKS)) == CYC_W'(CAP_PH));
    end

    // Linear screen address of the word being fetched.
    always_comb begin
        rd_addr = ADDR_W'(row_f) * ADDR_W'(ROW_WORDS)
                + ADDR_W'(slot_f) * ADDR_W'(LINES)
                + (fetch_en ? ADDR_W'(word_idx) : '0);
    end

    for (genvar j = 0; j < LINES; j++) begin : g_cap
        // Capture the returned word for line j.
        always_ff @(posedge clk) begin
            if (capture && (word_idx == LINE_W'(j)))
                fetch_buf[j] <= rd_data;
        end
    end

endmodule

// File: rtl/ledmx_serial.sv
// Module: column serializer.
// Copies the fetched words into a shift-side holding register at each slot
// boundary and presents bit (WORD_W-1-bit_idx) of word j on line j.
// Assumes bit_idx stays below WORD_W while shift_active is high.
module ledmx_serial #(
    parameter int LINES  = 16,
    parameter int WORD_W = 16,
    parameter int BIT_W  = 4
) (
    input  logic                          clk,
    input  logic                          load,
    input  logic [LINES-1:0][WORD_W-1:0]  fetch_buf,
    input  logic                          shift_active,
    input  logic [BIT_W-1:0]              bit_idx,
    output logic [LINES-1:0]              col_data
);

    logic [LINES-1:0][WORD_W-1:0] hold;

    // Take over the prefetched slot at the slot boundary.
    always_ff @(posedge clk) begin
        if (load)
            hold <= fetch_buf;
    end

    for (genvar j = 0; j < LINES; j++) begin : g_line
        // Transpose: line j serializes word j, most significant bit first.
        assign col_data[j] = shift_active && hold[j][BIT_W'(WORD_W - 1) - bit_idx];
    end

endmodule

// File: rtl/ledmx_scan_ctrl.sv
// Module: LED matrix scan controller top.
// Joins the slot timing, the fetch unit and the column serializer, and brings
// the end-of-line strobes to the pins.
// Assumes a one-clock-latency frame buffer; bank swapping is done outside on
// frame_pulse.
module ledmx_scan_ctrl
    import ledmx_pkg::*;
#(
    parameter int LINES         = 16,
    parameter int WORD_W        = 16,
    parameter int SLOTS_PER_ROW = 12,
    parameter int ROW_GROUPS    = 8,
    parameter int SLOT_CLKS     = 64,
    parameter int FETCH_CLKS    = 4,
    parameter int BIT_CLKS      = 2,
    parameter int ADDR_W        = $clog2(ROW_GROUPS * SLOTS_PER_ROW * LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [WORD_W-1:0]  rd_data,
    output logic [LINES-1:0]   col_data,
    output logic               col_clk,
    output logic               col_latch,
    output logic               row_data,
    output logic               row_clk,
    output logic               row_latch,
    output logic               frame_pulse
);

    localparam int CYC_W       = $clog2(SLOT_CLKS);
    localparam int SLOT_W      = $clog2(SLOTS_PER_ROW);
    localparam int ROW_W       = $clog2(ROW_GROUPS);
    localparam int BIT_W       = $clog2(WORD_W);
    localparam int LINE_W      = $clog2(LINES);
    localparam int FRAME_WORDS = ROW_GROUPS * SLOTS_PER_ROW * LINES;

    logic [CYC_W-1:0]             cyc;
    logic [ROW_W-1:0]             row_f;
    logic [SLOT_W-1:0]            slot_f;
    logic                         slot_end;
    logic                         shift_active;
    logic [BIT_W-1:0]             bit_idx;
    ledmx_evt_t                   evt;
    logic [LINES-1:0][WORD_W-1:0] fetch_buf;

    ledmx_timing #(
        .SLOT_CLKS(SLOT_CLKS), .SLOTS_PER_ROW(SLOTS_PER_ROW),
        .ROW_GROUPS(ROW_GROUPS), .WORD_W(WORD_W), .BIT_CLKS(BIT_CLKS),
        .CYC_W(CYC_W), .SLOT_W(SLOT_W), .ROW_W(ROW_W), .BIT_W(BIT_W)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .row_f(row_f), .slot_f(slot_f),
        .slot_end(slot_end), .shift_active(shift_active), .col_clk(col_clk),
        .bit_idx(bit_idx), .evt(evt)
    );

    ledmx_fetch #(
        .LINES(LINES), .WORD_W(WORD_W), .SLOTS_PER_ROW(SLOTS_PER_ROW),
        .FETCH_CLKS(FETCH_CLKS), .CYC_W(CYC_W), .ROW_W(ROW_W),
        .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)
    ) u_fetch (
        .clk(clk), .cyc(cyc), .row_f(row_f), .slot_f(slot_f),
        .rd_addr(rd_addr), .rd_data(rd_data), .fetch_buf(fetch_buf)
    );

    ledmx_serial #(
        .LINES(LINES), .WORD_W(WORD_W), .BIT_W(BIT_W)
    ) u_serial (
        .clk(clk), .load(slot_end), .fetch_buf(fetch_buf),
        .shift_active(shift_active), .bit_idx(bit_idx), .col_data(col_data)
    );

    // Strobes to pins.
    always_comb begin
        col_latch   = evt.col_latch;
        row_data    = evt.row_data;
        row_clk     = evt.row_clk;
        row_latch   = evt.row_latch;
        frame_pulse = evt.frame;
    end

endmodule

// File: rtl/ledmx_checker.sv
// Module: protocol checker for the scan controller, bound to the top.
// Assumes the default strobe spacing of the timing unit.
module ledmx_checker #(
    parameter int ADDR_W      = 11,
    parameter int LINES       = 16,
    parameter int FRAME_WORDS = 1536
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [LINES-1:0]  col_data,
    input logic              col_clk,
    input logic              col_latch,
    input logic              row_data,
    input logic              row_clk,
    input logic              row_latch,
    input logic              frame_pulse
);

    AST_ADDR_IN_SCREEN: assert property (@(posedge clk) disable iff (!rst_n) rd_addr < ADDR_W'(FRAME_WORDS)); // R2
    AST_COL_DATA_SETTLED: assert property (@(posedge clk) disable iff (!rst_n) col_clk |-> $stable(col_data)); // R3
    AST_COL_CLK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) col_clk |=> !col_clk); // R4
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({col_clk, col_latch, row_clk, row_latch, frame_pulse})); // R5
    AST_ROW_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n) row_clk |-> $stable(row_data)); // R6
    AST_ROW_CLK_AFTER_COL_LATCH: assert property (@(posedge clk) disable iff (!rst_n) row_clk |-> $past(col_latch, 6)); // R6
    AST_ROW_LATCH_AFTER_ROW_CLK: assert property (@(posedge clk) disable iff (!rst_n) row_latch |-> $past(row_clk, 4)); // R7
    AST_FRAME_AFTER_ROW_LATCH: assert property (@(posedge clk) disable iff (!rst_n) frame_pulse |-> $past(row_latch)); // R8

endmodule

bind ledmx_scan_ctrl ledmx_checker #(
    .ADDR_W(ADDR_W), .LINES(LINES), .FRAME_WORDS(FRAME_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .col_data(col_data),
    .col_clk(col_clk), .col_latch(col_latch), .row_data(row_data),
    .row_clk(row_clk), .row_latch(row_latch), .frame_pulse(frame_pulse)
);

// File: tb/ledmx_scan_ctrl_bench.sv
// Bench: cycle-exact comparison of every output against an arithmetic model
// of the slot schedule, over two frames with a mid-frame reset.
module ledmx_scan_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] rd_addr;
    logic [15:0] rd_data = '0;
    logic [15:0] col_data;
    logic        col_clk, col_latch, row_data, row_clk, row_latch, frame_pulse;

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit done = 1'b0;
    bit after_mid = 1'b0;
    bit seen_first_frame = 1'b0;
    bit seen_mid_frame = 1'b0;
    bit seen_mid_clk = 1'b0;
    logic [7:0] row_sr = '0;
    logic prev_row_clk = 1'b0;
    logic prev_row_latch = 1'b0;

    always #10 clk = ~clk;

    ledmx_scan_ctrl u_ledmx_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .col_data(col_data), .col_clk(col_clk), .col_latch(col_latch),
        .row_data(row_data), .row_clk(row_clk), .row_latch(row_latch),
        .frame_pulse(frame_pulse)
    );

    function automatic logic [15:0] pat(int a);
        return 16'((a * 40503 + 12345) ^ (a << 5) ^ (a >> 2));
    endfunction

    // Frame buffer model: one clock read latency.
    always @(posedge clk) rd_data <= pat(int'(rd_addr));

    // Active clock edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at n=%0d: actual=%0h expected=%0h", tag, what, n, act, exp);
        end
    endtask

    // Per-cycle comparison, sampled away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            int c, g, q, p, r, s, pf, rf, sf;
            logic valid, rowend;
            logic [15:0] exp_col;
            c = n % 64;
            g = n / 64;
            valid = (g >= 1);
            q = valid ? g - 1 : 0;
            p = q % 96;
            r = p / 12;
            s = p % 12;
            pf = g % 96;
            rf = pf / 12;
            sf = pf % 12;
            rowend = valid && (s == 11);
            for (int j = 0; j < 16; j++) begin
                logic [15:0] w;
                w = pat(r * 192 + s * 16 + j);
                exp_col[j] = (valid && c < 32) ? w[15 - c / 2] : 1'b0;
            end
            if (!rst_n && n == 0) begin
                chk("R1", "reset addr", 32'(rd_addr), 0);
                chk("R1", "reset strobes", {27'd0, col_clk, col_latch, row_clk, row_latch, frame_pulse}, 0);
                chk("R1", "reset data", {15'd0, row_data, col_data}, 0);
                row_sr = '0;
            end
            chk("R2", "rd_addr", 32'(rd_addr), 32'(rf * 192 + sf * 16 + c / 4));
            chk("R3", "col_data", 32'(col_data), 32'(exp_col));
            chk("R4", "col_clk", 32'(col_clk), 32'(valid && c < 32 && (c % 2) == 1));
            chk("R5", "col_latch", 32'(col_latch), 32'(rowend && c == 40));
            chk("R6", "row_data", 32'(row_data), 32'(rowend && r == 0 && c >= 44 && c <= 47));
            chk("R6", "row_clk", 32'(row_clk), 32'(rowend && c == 46));
            chk("R7", "row_latch", 32'(row_latch), 32'(rowend && c == 50));
            chk("R8", "frame_pulse", 32'(frame_pulse), 32'(rowend && r == 7 && c == 51));
            // External row-select chain model.
            if (row_clk && !prev_row_clk) row_sr = {row_sr[6:0], row_data};
            if (row_latch && !prev_row_latch)
                chk("R6", "latched row select", 32'(row_sr), 32'(8'd1 << r));
            prev_row_clk = row_clk;
            prev_row_latch = row_latch;
            if (frame_pulse && !after_mid && !seen_first_frame) begin
                seen_first_frame = 1'b1;
                chk("R8", "first frame pulse time", 32'(n), 6195);
            end
            if (frame_pulse && after_mid && !seen_mid_frame) begin
                seen_mid_frame = 1'b1;
                chk("R9", "frame pulse time after mid reset", 32'(n), 6195);
            end
            if (col_clk && after_mid && !seen_mid_clk) begin
                seen_mid_clk = 1'b1;
                chk("R9", "first col_clk after mid reset", 32'(n), 65);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (8000) @(posedge clk);
        #2 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        after_mid = 1'b1;
        repeat (6400) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        chk("R8", "frame pulse seen", 32'(seen_first_frame), 1);
        chk("R9", "frame pulse seen after mid reset", 32'(seen_mid_frame), 1);
        chk("R9", "col_clk seen after mid reset", 32'(seen_mid_clk), 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R8: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule